// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two signed two's-complement operands of width `W` over several clock cycles. A one-cycle `start` pulse while the block is idle captures the multiplicand and the multiplier. The block then runs exactly `W` iterations. Each iteration looks at the lowest multiplier bit and the bit shifted out just before it. That pair decides whether the multiplicand is added to the running upper half, subtracted from it, or left alone. The upper half, the multiplier register and the guard bit then shift right together by one place, and the shift copies the sign.

When the last iteration completes, `busy` drops and `done` rises. The full `2W`-bit signed product then sits on `product` and does not change until the next accepted `start`. A negative multiplier needs no conversion step. The most negative multiplicand is handled correctly, because the sign shifted into the upper half is taken from a one-bit-wider sum and not from the wrapped `W`-bit result.

Top module: `booth_seq_mult`

## Requirements
- R1: During and after synchronous reset, with no start since then, `busy`, `done` and `product` are all zero.
- R2: `start` high while `busy` is low captures `mcand` and `mplier` at that clock edge. On the next cycle `busy` is 1 and `done` is 0.
- R3: `done` rises exactly `W` clock edges after the accepting edge. `product` then equals the signed product of the captured operands as a `2W`-bit two's-complement value.
- R4: Negative multipliers (sign bit 1) give the correct signed product with no extra step. The pair (multiplier bit 0, guard bit) means: 01 add, 10 subtract, 00 and 11 shift only.
- R5: A multiplicand equal to -2^(W-1) gives the correct product with every multiplier, including another most negative value.
- R6: While `done` is high and `start` is low, `done` stays high and `product` holds its value.
- R7: While `busy` is high, `start` and changes on `mcand`/`mplier` have no effect on the running product or on its completion time.
- R8: `busy` and `done` are never high in the same cycle.
- R9: At `W`=5, multiplicand -13 (5'b10011) times multiplier 8 (5'b01000) yields 10'b1110011000 (-104).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply; taken only while idle |
| mcand | input | W | Signed multiplicand |
| mplier | input | W | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | Product valid; held until the next accepted start |
| product | output | 2W | Signed product, upper half from accumulator, lower half from multiplier register |

## Verification
The bench builds two copies of the block. The first uses `W`=5, which makes exhaustive coverage possible: all 1024 operand pairs, including the most negative values on both sides and the worked -13 by 8 case. The second uses `W`=16. It takes directed corner operands (zero, extremes, alternating bit patterns that force an operation on every iteration) and then random pairs. At this width any mix-up between the true sign and the wrapped sign in the accumulator would be seen across long runs of iterations. Both copies are driven with stray start pulses and changed operand inputs during a run, and they are checked for their exact completion latency.

// File: rtl/booth_pkg.sv
// Shared types for the Booth multiplier.
// Assumes: nothing beyond a SystemVerilog-2017 compiler.
package booth_pkg;

    // Action chosen for one iteration from the (bit0, guard) pair
    typedef enum logic [1:0] {
        BOOTH_HOLD = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-2 recoder: maps the lowest multiplier bit and the guard bit
// onto add / subtract / hold.
// Assumes: guard bit holds the multiplier bit shifted out last (0 at load).
module booth_recode
    import booth_pkg::*;
(
    input  logic      lsb,
    input  logic      guard,
    output booth_op_e op
);

    // Decode the bit pair into the iteration's action
    always_comb begin
        unique case ({lsb, guard})
            2'b01:   op = BOOTH_ADD;
            2'b10:   op = BOOTH_SUB;
            default: op = BOOTH_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_addsub.sv
// Accumulator adder: acc +/- m, or acc unchanged.
// It returns the W-bit wrapped sum and the true sign of the exact result.
// The true sign comes from a W+1 bit sign-extended sum, so -m never has
// to fit in W bits.
// Assumes: acc and m are signed two's complement.
module booth_addsub
    import booth_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] m,
    input  booth_op_e    op,
    output logic [W-1:0] sum,
    output logic         sign
);

    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] total;
    logic       cin;

    // Select the addend and the carry-in from the recoded action
    always_comb begin
        a_ext = {acc[W-1], acc};
        unique case (op)
            BOOTH_ADD: begin b_ext = {m[W-1], m};    cin = 1'b0; end
            BOOTH_SUB: begin b_ext = ~{m[W-1], m};   cin = 1'b1; end
            default:   begin b_ext = '0;             cin = 1'b0; end
        endcase
        total = a_ext + b_ext + {{W{1'b0}}, cin};
        sum   = total[W-1:0];
        sign  = total[W];
    end

endmodule

// File: rtl/booth_seq_ctrl.sv
// Sequencer: accepts start while idle and runs exactly W iteration
// cycles. It then raises done and holds it until the next accepted start.
// Assumes: W >= 2.
module booth_seq_ctrl #(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] iter_q;

    // A start is taken only while no run is in progress
    assign load = start && !busy;
    assign step = busy;

    // Track busy/done and count the iterations
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            iter_q <= '0;
        end else if (load) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            iter_q <= '0;
        end else if (busy) begin
            if (iter_q == LAST) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                iter_q <= '0;
            end else begin
                iter_q <= iter_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
// Top: sequential radix-2 Booth multiplier.
// Registers: acc (upper half), mq (multiplier, becomes the lower half),
// guard bit, and the captured multiplicand. Each step adds or subtracts the
// multiplicand as recoded, then shifts {acc, mq, guard} right arithmetically.
// Assumes: operands are signed two's complement; W >= 2.
module booth_seq_mult #(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);

    import booth_pkg::*;

    logic [W-1:0] acc_q;
    logic [W-1:0] mq_q;
    logic [W-1:0] mcand_q;
    logic         guard_q;
    logic         load;
    logic         step;
    booth_op_e    op;
    logic [W-1:0] sum;
    logic         sum_sign;

    booth_seq_ctrl #(.W(W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    booth_recode u_recode (
        .lsb   (mq_q[0]),
        .guard (guard_q),
        .op    (op)
    );

    booth_addsub #(.W(W)) u_addsub (
        .acc  (acc_q),
        .m    (mcand_q),
        .op   (op),
        .sum  (sum),
        .sign (sum_sign)
    );

    // Load operands on start; otherwise add/sub then arithmetic right shift
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mq_q    <= '0;
            mcand_q <= '0;
            guard_q <= 1'b0;
        end else if (load) begin
            acc_q   <= '0;
            mq_q    <= mplier;
            mcand_q <= mcand;
            guard_q <= 1'b0;
        end else if (step) begin
            acc_q   <= {sum_sign, sum[W-1:1]};
            mq_q    <= {sum[0], mq_q[W-1:1]};
            guard_q <= mq_q[0];
        end
    end

    assign product = {acc_q, mq_q};

endmodule

// File: rtl/booth_seq_mult_chk.sv
// Protocol checker for booth_seq_mult, attached by bind.
// Assumes: reset is asserted at the first clock edge.
module booth_seq_mult_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);

    localparam int CW = $clog2(W + 2) + 1;

    logic [CW-1:0] run_cyc;

    // Count the busy cycles since the last accepted start
    always_ff @(posedge clk) begin
        if (!rst_n)                run_cyc <= '0;
        else if (start && !busy)   run_cyc <= '0;
        else if (busy)             run_cyc <= run_cyc + 1'b1;
    end

    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r2_start_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    a_r6_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(product)));

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (run_cyc == CW'(W)));

endmodule

bind booth_seq_mult booth_seq_mult_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product)
);

// File: tb/booth_seq_mult_test.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers push expected products into queues and
// monitors pop and compare them when done rises.
module booth_seq_mult_test;

    localparam int WW = 16;
    localparam int WN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // wide instance
    logic            start_w = 1'b0;
    logic [WW-1:0]   mcand_w = '0, mplier_w = '0;
    logic            busy_w, done_w;
    logic [2*WW-1:0] prod_w;

    booth_seq_mult #(.W(WW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start_w), .mcand(mcand_w),
        .mplier(mplier_w), .busy(busy_w), .done(done_w), .product(prod_w)
    );

    // narrow instance
    logic            start_n = 1'b0;
    logic [WN-1:0]   mcand_n = '0, mplier_n = '0;
    logic            busy_n, done_n;
    logic [2*WN-1:0] prod_n;

    booth_seq_mult #(.W(WN)) uut_small (
        .clk(clk), .rst_n(rst_n), .start(start_n), .mcand(mcand_n),
        .mplier(mplier_n), .busy(busy_n), .done(done_n), .product(prod_n)
    );

    logic [2*WW-1:0] exp_w[$];
    string           tag_w[$];
    logic [2*WN-1:0] exp_n[$];
    string           tag_n[$];

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compare the narrow product when done rises
    logic done_n_prev = 1'b0;
    always @(negedge clk) begin
        if (done_n && !done_n_prev) begin
            if (exp_n.size() == 0) check(1'b0, "R3 unexpected", longint'(prod_n), 0);
            else begin
                logic [2*WN-1:0] e;
                string t;
                e = exp_n.pop_front();
                t = tag_n.pop_front();
                check(prod_n == e, t, longint'(prod_n), longint'(e));
            end
        end
        done_n_prev = done_n;
    end

    // Monitor: compare the wide product when done rises
    logic done_w_prev = 1'b0;
    always @(negedge clk) begin
        if (done_w && !done_w_prev) begin
            if (exp_w.size() == 0) check(1'b0, "R3 unexpected", longint'(prod_w), 0);
            else begin
                logic [2*WW-1:0] e;
                string t;
                e = exp_w.pop_front();
                t = tag_w.pop_front();
                check(prod_w == e, t, longint'(prod_w), longint'(e));
            end
        end
        done_w_prev = done_w;
    end

    // Narrow driver: one multiply with optional stray start and hold check
    task automatic do_narrow(input int a, input int b, input bit poke, input bit hold, input string tag);
        logic [2*WN-1:0] e;
        int n;
        e = (2*WN)'(a * b);
        @(negedge clk);
        mcand_n = WN'(a); mplier_n = WN'(b); start_n = 1'b1;
        exp_n.push_back(e); tag_n.push_back(tag);
        @(negedge clk);
        start_n = 1'b0;
        n = 1;
        if (poke) check(busy_n && !done_n, "R2 busy after start", longint'({busy_n, done_n}), 2);
        mcand_n = ~WN'(a); mplier_n = WN'(b + 3);   // R7: inputs change mid-run
        while (!done_n && n < 100) begin
            start_n = (poke && n == 2);              // R7: stray start while busy
            @(negedge clk);
            n++;
        end
        start_n = 1'b0;
        if (poke) check(n == WN + 1, "R3/R7 latency", longint'(n), longint'(WN + 1));
        if (hold) begin
            repeat (3) @(negedge clk);
            check(done_n && prod_n == e, "R6 hold", longint'(prod_n), longint'(e));
        end
    endtask

    // Wide driver: one multiply with optional stray start
    task automatic do_wide(input int a, input int b, input bit poke, input string tag);
        logic [2*WW-1:0] e;
        int n;
        e = (2*WW)'(longint'(a) * longint'(b));
        @(negedge clk);
        mcand_w = WW'(a); mplier_w = WW'(b); start_w = 1'b1;
        exp_w.push_back(e); tag_w.push_back(tag);
        @(negedge clk);
        start_w = 1'b0;
        n = 1;
        mcand_w = WW'(b); mplier_w = WW'(a);         // R7: inputs change mid-run
        while (!done_w && n < 100) begin
            start_w = (poke && n == 5);
            @(negedge clk);
            n++;
        end
        start_w = 1'b0;
        check(n == WW + 1, "R3 latency", longint'(n), longint'(WW + 1));
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy_w && !done_w && prod_w == '0, "R1 reset wide", longint'(prod_w), 0);
        check(!busy_n && !done_n && prod_n == '0, "R1 reset narrow", longint'(prod_n), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_n && !done_n && prod_n == '0, "R1 idle after reset", longint'(prod_n), 0);

        // R9: worked example
        do_narrow(-13, 8, 1'b1, 1'b1, "R9");
        check(prod_n == 10'b1110011000, "R9 direct", longint'(prod_n), 10'b1110011000);

        // R3 R4 R5: exhaustive narrow operands
        for (int a = -16; a < 16; a++) begin
            for (int b = -16; b < 16; b++) begin
                string t;
                t = (a == -16) ? "R5" : (b < 0) ? "R4" : "R3";
                do_narrow(a, b, ((a + b) % 13) == 0, ((a * 7 + b) % 97) == 0, t);
            end
        end

        // R3 R4 R5: directed wide corners, then random
        do_wide(0, 0, 1'b0, "R3 zero");
        do_wide(32767, 32767, 1'b1, "R3 max");
        do_wide(-32768, -32768, 1'b0, "R5 min*min");
        do_wide(-32768, 1, 1'b1, "R5 min*1");
        do_wide(-32768, 32767, 1'b0, "R5 min*max");
        do_wide(12345, -1, 1'b0, "R4 neg one");
        do_wide(-1234, 16'h5555, 1'b0, "R4 alt 0101");
        do_wide(777, -21846, 1'b1, "R4 alt 1010");
        for (int i = 0; i < 400; i++) begin
            int a, b;
            a = int'($signed(16'($urandom())));
            b = int'($signed(16'($urandom())));
            do_wide(a, b, (i % 7) == 0, (b < 0) ? "R4 random" : "R3 random");
        end
        repeat (4) @(negedge clk);
        check(exp_w.size() == 0 && exp_n.size() == 0, "R3 scoreboard drained",
              longint'(exp_w.size() + exp_n.size()), 0);
        check(!(busy_w && done_w) && !(busy_n && done_n), "R8 exclusive", 0, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule